// File: doc/BRIEF.md
# Protocol and Port Traffic Classifier

This block sits in front of two inspection queues and decides, for every Ethernet frame carrying IPv4, which queue should receive it. Bytes arrive one per clock. The block reads the EtherType, the IP version and header length, the IP protocol number and, for TCP and UDP, the destination port. From these it produces a one-hot queue select. Web traffic on TCP goes to queue A. All other TCP goes to queue B. UDP and ICMP go to a queue chosen by a configuration pin, and everything else goes to queue B.

The frame passes through unchanged behind a fixed delay. That delay is as long as the deepest possible header, from the start of the frame to the last byte of the port field. Because of this, the decision is always ready when the first byte leaves the block, and the select can travel alongside the whole frame. A frame that ends before its deciding byte is sent to queue B and flagged as malformed. The block has no ready signal and never back-pressures its source, so the write side of the queues keeps running even while the inspection side is busy elsewhere.

Top module: `proto_port_classifier`

## Requirements
- R1: A frame with EtherType 0x0800, IP version 4, header length IHL of 5 or more and protocol number 6 (TCP), whose destination port equals `WEB_PORT` (default 80, big-endian), is tagged for queue A: `out_sel` = 2'b01 (bit 0 = queue A, bit 1 = queue B).
- R2: A TCP frame whose destination port differs from `WEB_PORT` is tagged for queue B: `out_sel` = 2'b10.
- R3: A frame with protocol 1 (ICMP) or 17 (UDP) is tagged for queue A when `misc_sel_b` is 0 and for queue B when it is 1. The pin is sampled while the frame is being received.
- R4: Frames with any other protocol number, with an EtherType other than 0x0800 (frame bytes 12 and 13), or with an IP version field other than 4 are tagged for queue B and are not flagged malformed.
- R5: The destination port is read at frame byte offsets 14+4*IHL+2 (high byte) and 14+4*IHL+3 (low byte). IHL is the low nibble of byte 14, and the version is the high nibble. This means IP options of any legal length are skipped correctly.
- R6: A frame that ends before its deciding byte is tagged for queue B with `out_malformed` = 1. The deciding byte is byte 13 for a wrong EtherType, byte 14 for the version/IHL byte, byte 23 for the protocol, and the port low byte for TCP and UDP. A frame whose IHL is below 5 is also tagged queue B and malformed.
- R7: Output data, start and end markers are the input ones delayed by exactly 78 clock cycles and otherwise unchanged. The input accepts a byte every cycle with no stall. Bytes of one frame must be presented on consecutive cycles.
- R8: While `out_valid` is 1, `out_sel` is one-hot. It is valid on the start byte and stays constant, together with `out_malformed`, through the end byte. While `out_valid` is 0, both are 0.
- R9: After reset, all outputs are 0.
- R10: Frames presented back to back, down to one-byte frames, each leave with their own tag, in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| misc_sel_b | input | 1 | Queue for UDP and ICMP: 0 = A, 1 = B |
| in_valid | input | 1 | Input byte present |
| in_sop | input | 1 | First byte of a frame |
| in_eop | input | 1 | Last byte of a frame |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte present |
| out_sop | output | 1 | First byte of a frame on the output |
| out_eop | output | 1 | Last byte of a frame on the output |
| out_data | output | 8 | Output byte, unchanged |
| out_sel | output | 2 | One-hot queue select, bit 0 = A, bit 1 = B |
| out_malformed | output | 1 | Frame too short or header length invalid |

## Verification
A wrong header offset, such as a mis-tracked byte index or a stale IHL, shows up as a wrong queue select on the start byte of the affected frame. That happens exactly 78 cycles after the frame enters. A tag queue that falls out of step shows up one frame later, when every following frame carries its neighbour's tag, and it never recovers. A broken delay stage corrupts data or markers at the output 78 cycles after the byte enters. The bench therefore compares every output cycle against the input history and every start byte against an arithmetically derived tag.

// File: rtl/pcls_pkg.sv
package pcls_pkg;

   localparam int BYTE_W = 8;

   localparam logic [7:0] PROTO_ICMP = 8'd1;
   localparam logic [7:0] PROTO_TCP  = 8'd6;
   localparam logic [7:0] PROTO_UDP  = 8'd17;

   typedef struct packed {
      logic              valid;
      logic              sop;
      logic              eop;
      logic [BYTE_W-1:0] data;
   } beat_t;

   typedef struct packed {
      logic to_b;
      logic bad;
   } tag_t;

endpackage

// File: rtl/pcls_delay.sv
module pcls_delay
   import pcls_pkg::*;
#(
   parameter int STAGES = 78
) (
   input  logic  clk,
   input  logic  rst_n,
   input  beat_t din,
   output beat_t dout
);

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("pcls_delay: STAGES must be at least 1");
      end
   endgenerate

   beat_t pipe [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[g] <= '0;
            else        pipe[g] <= din;
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[g] <= '0;
            else        pipe[g] <= pipe[g-1];
         end
      end
   end

   assign dout = pipe[STAGES-1];

endmodule

// File: rtl/pcls_tag_fifo.sv
module pcls_tag_fifo #(
   parameter int DEPTH = 128,
   parameter int W     = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full
);

   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH != (1 << AW)) begin : g_bad_depth
         $error("pcls_tag_fifo: DEPTH must be a power of two");
      end
   endgenerate

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wr_q, rd_q;

   assign empty = (wr_q == rd_q);
   assign full  = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
   assign rdata = mem[rd_q[AW-1:0]];

   always_ff @(posedge clk) begin
      if (push) mem[wr_q[AW-1:0]] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q <= '0;
         rd_q <= '0;
      end else begin
         if (push) wr_q <= wr_q + 1'b1;
         if (pop)  rd_q <= rd_q + 1'b1;
      end
   end

   // R10
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);

   // R10
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);

endmodule

// File: rtl/pcls_parser.sv
module pcls_parser
   import pcls_pkg::*;
#(
   parameter int          ETH_HDR_LEN  = 14,
   parameter logic [15:0] ETHERTYPE_IP = 16'h0800,
   parameter logic [15:0] WEB_PORT     = 16'd80,
   parameter int          IDX_W        = 7
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  misc_sel_b,
   input  beat_t ib,
   output logic  dec_push,
   output tag_t  dec_tag
);

   localparam int IDX_ET_HI = ETH_HDR_LEN - 2;
   localparam int IDX_ET_LO = ETH_HDR_LEN - 1;
   localparam int IDX_VIHL  = ETH_HDR_LEN;
   localparam int IDX_PROTO = ETH_HDR_LEN + 9;
   localparam logic [IDX_W-1:0] IDX_MAX = '1;

   generate
      if (ETH_HDR_LEN < 2) begin : g_bad_hdr
         $error("pcls_parser: Ethernet header must hold the EtherType");
      end
      if ((1 << IDX_W) <= ETH_HDR_LEN + 64) begin : g_bad_idx
         $error("pcls_parser: IDX_W too narrow for the deepest port field");
      end
   endgenerate

   logic [IDX_W-1:0] cnt_q, idx, port_lo;
   logic             done_q, open, dec, to_b, bad;
   logic [7:0]       et_hi_q, port_hi_q;
   logic [3:0]       ihl_q;
   logic             tcp_q;

   always_comb begin
      idx     = ib.sop ? '0 : cnt_q;
      open    = ib.valid && (ib.sop || !done_q);
      port_lo = IDX_W'(ETH_HDR_LEN + 3 + 4 * int'(ihl_q));
      dec     = 1'b0;
      to_b    = 1'b1;
      bad     = 1'b0;
      if (open) begin
         if (idx == IDX_W'(IDX_ET_LO)) begin
            if ({et_hi_q, ib.data} != ETHERTYPE_IP) dec = 1'b1;
         end else if (idx == IDX_W'(IDX_VIHL)) begin
            if (ib.data[7:4] != 4'd4) begin
               dec = 1'b1;
            end else if (ib.data[3:0] < 4'd5) begin
               dec = 1'b1;
               bad = 1'b1;
            end
         end else if (idx == IDX_W'(IDX_PROTO)) begin
            if (ib.data == PROTO_ICMP) begin
               dec  = 1'b1;
               to_b = misc_sel_b;
            end else if (ib.data != PROTO_TCP && ib.data != PROTO_UDP) begin
               dec = 1'b1;
            end
         end else if (idx == port_lo) begin
            dec  = 1'b1;
            to_b = tcp_q ? ({port_hi_q, ib.data} != WEB_PORT) : misc_sel_b;
         end
         if (!dec && ib.eop) begin
            dec  = 1'b1;
            to_b = 1'b1;
            bad  = 1'b1;
         end
      end
   end

   assign dec_push     = dec;
   assign dec_tag.to_b = to_b;
   assign dec_tag.bad  = bad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         done_q    <= 1'b0;
         et_hi_q   <= '0;
         port_hi_q <= '0;
         ihl_q     <= '0;
         tcp_q     <= 1'b0;
      end else if (ib.valid) begin
         cnt_q  <= (idx == IDX_MAX) ? idx : idx + 1'b1;
         done_q <= (ib.sop ? 1'b0 : done_q) | dec;
         if (idx == IDX_W'(IDX_ET_HI)) et_hi_q <= ib.data;
         if (idx == IDX_W'(IDX_VIHL))  ihl_q   <= ib.data[3:0];
         if (idx == IDX_W'(IDX_PROTO)) tcp_q   <= (ib.data == PROTO_TCP);
         if (idx == port_lo - 1'b1)    port_hi_q <= ib.data;
      end
   end

   // R6
   last_byte_decides_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ib.valid && ib.eop && !ib.sop && done_q) |-> !dec_push);

endmodule

// File: rtl/proto_port_classifier.sv
module proto_port_classifier
   import pcls_pkg::*;
#(
   parameter int          ETH_HDR_LEN  = 14,
   parameter logic [15:0] ETHERTYPE_IP = 16'h0800,
   parameter logic [15:0] WEB_PORT     = 16'd80
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       misc_sel_b,
   input  logic       in_valid,
   input  logic       in_sop,
   input  logic       in_eop,
   input  logic [7:0] in_data,
   output logic       out_valid,
   output logic       out_sop,
   output logic       out_eop,
   output logic [7:0] out_data,
   output logic [1:0] out_sel,
   output logic       out_malformed
);

   localparam int MAX_IHL   = 15;
   localparam int DLY       = ETH_HDR_LEN + 4 * MAX_IHL + 4;
   localparam int IDX_W     = $clog2(DLY + 1);
   localparam int TAG_DEPTH = 1 << $clog2(DLY + 1);
   localparam int TAG_W     = $bits(tag_t);

   beat_t ib, ob;
   logic  dec_push, pop, empty, full;
   tag_t  dec_tag, head, hold_q, cur;
   logic [TAG_W-1:0] head_raw;

   assign ib = '{valid: in_valid, sop: in_sop, eop: in_eop, data: in_data};

   pcls_parser #(
      .ETH_HDR_LEN (ETH_HDR_LEN),
      .ETHERTYPE_IP(ETHERTYPE_IP),
      .WEB_PORT    (WEB_PORT),
      .IDX_W       (IDX_W)
   ) u_parser (
      .clk       (clk),
      .rst_n     (rst_n),
      .misc_sel_b(misc_sel_b),
      .ib        (ib),
      .dec_push  (dec_push),
      .dec_tag   (dec_tag)
   );

   pcls_delay #(.STAGES(DLY)) u_delay (
      .clk (clk),
      .rst_n(rst_n),
      .din (ib),
      .dout(ob)
   );

   pcls_tag_fifo #(.DEPTH(TAG_DEPTH), .W(TAG_W)) u_tags (
      .clk  (clk),
      .rst_n(rst_n),
      .push (dec_push),
      .wdata(dec_tag),
      .pop  (pop),
      .rdata(head_raw),
      .empty(empty),
      .full (full)
   );

   assign head = tag_t'(head_raw);
   assign pop  = ob.valid && ob.sop;
   assign cur  = pop ? head : hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  hold_q <= '0;
      else if (ob.valid && ob.eop) hold_q <= '0;
      else if (pop)                hold_q <= head;
   end

   assign out_valid     = ob.valid;
   assign out_sop       = ob.sop;
   assign out_eop       = ob.eop;
   assign out_data      = ob.data;
   assign out_sel       = !ob.valid ? 2'b00 : (cur.to_b ? 2'b10 : 2'b01);
   assign out_malformed = ob.valid && cur.bad;

   // R8
   tag_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $countones(out_sel) == 1);

   // R8
   tag_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_sel == 2'b00) && !out_malformed);

   // R8
   tag_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_sop) |-> $stable(out_sel) && $stable(out_malformed));

   // R6
   malformed_to_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_malformed |-> out_sel == 2'b10);

endmodule

// File: tb/test_proto_port_classifier.sv
module test_proto_port_classifier;

   localparam int DLY = 78;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       misc_sel_b = 1'b0;
   logic       in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       out_valid, out_sop, out_eop, out_malformed;
   logic [7:0] out_data;
   logic [1:0] out_sel;

   proto_port_classifier i_proto_port_classifier (
      .clk(clk), .rst_n(rst_n), .misc_sel_b(misc_sel_b),
      .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
      .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
      .out_data(out_data), .out_sel(out_sel), .out_malformed(out_malformed)
   );

   always #4 clk = ~clk;

   int checks = 0, fails = 0, cyc = 0;
   bit mon_on = 1'b0, finished = 1'b0;
   logic [10:0] hist [0:255];
   logic [1:0]  exp_sel [0:1023];
   logic        exp_bad [0:1023];
   string       exp_req [0:1023];
   int          wr_p = 0, rd_p = 0;
   logic [1:0]  cur_sel = 2'b00;
   logic        cur_bad = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   always @(negedge clk) begin
      logic [10:0] e;
      hist[cyc % 256] = {in_valid, in_sop, in_eop, in_data};
      if (mon_on) begin
         if (cyc >= DLY) begin
            e = hist[(cyc - DLY) % 256];
            check({out_valid, out_sop, out_eop, out_data} == e, "R7", "delayed beat",
                  int'({out_valid, out_sop, out_eop, out_data}), int'(e));
         end
         if (out_valid && out_sop) begin
            if (rd_p == wr_p) begin
               check(1'b0, "R10", "unexpected frame", 1, 0);
            end else begin
               check(out_sel == exp_sel[rd_p], exp_req[rd_p], "queue select",
                     int'(out_sel), int'(exp_sel[rd_p]));
               check(out_malformed == exp_bad[rd_p], exp_req[rd_p], "malformed flag",
                     int'(out_malformed), int'(exp_bad[rd_p]));
               cur_sel = exp_sel[rd_p];
               cur_bad = exp_bad[rd_p];
               rd_p++;
            end
         end else if (out_valid) begin
            check(out_sel == cur_sel && out_malformed == cur_bad, "R8", "tag held",
                  int'({out_malformed, out_sel}), int'({cur_bad, cur_sel}));
         end else begin
            check(out_sel == 2'b00 && !out_malformed, "R8", "idle tag",
                  int'({out_malformed, out_sel}), 0);
         end
      end
      cyc++;
   end

   function automatic logic [7:0] pbyte(input int i, input logic [15:0] et,
                                        input logic [3:0] ver, input logic [3:0] ihl,
                                        input logic [7:0] proto, input logic [15:0] port);
      int pl;
      pl = 14 + 4 * int'(ihl) + 3;
      if (i == 12) return et[15:8];
      if (i == 13) return et[7:0];
      if (i == 14) return {ver, ihl};
      if (i == 23) return proto;
      if (i > 23 && i == pl - 1) return port[15:8];
      if (i > 23 && i == pl) return port[7:0];
      return 8'(i * 37 + 5);
   endfunction

   task automatic send(input logic [15:0] et, input logic [3:0] ver, input logic [3:0] ihl,
                       input logic [7:0] proto, input logic [15:0] port, input int len,
                       input bit misc, input int gap, input string req_ovr);
      int    need;
      bit    to_b, bad;
      string req;
      bad = 1'b0;
      if (et != 16'h0800) begin
         need = 14; to_b = 1'b1; req = "R4";
      end else if (ver != 4'd4) begin
         need = 15; to_b = 1'b1; req = "R4";
      end else if (ihl < 4'd5) begin
         need = 15; to_b = 1'b1; bad = 1'b1; req = "R6";
      end else if (proto == 8'd1) begin
         need = 24; to_b = misc; req = "R3";
      end else if (proto == 8'd6) begin
         need = 14 + 4 * int'(ihl) + 4; to_b = (port != 16'd80);
         req = (ihl != 4'd5) ? "R5" : (to_b ? "R2" : "R1");
      end else if (proto == 8'd17) begin
         need = 14 + 4 * int'(ihl) + 4; to_b = misc;
         req = (ihl != 4'd5) ? "R5" : "R3";
      end else begin
         need = 24; to_b = 1'b1; req = "R4";
      end
      if (len < need) begin
         to_b = 1'b1; bad = 1'b1; req = "R6";
      end
      if (req_ovr != "") req = req_ovr;
      exp_sel[wr_p] = to_b ? 2'b10 : 2'b01;
      exp_bad[wr_p] = bad;
      exp_req[wr_p] = req;
      wr_p++;
      for (int i = 0; i < len; i++) begin
         @(posedge clk); #2;
         in_valid   = 1'b1;
         in_sop     = (i == 0);
         in_eop     = (i == len - 1);
         in_data    = pbyte(i, et, ver, ihl, proto, port);
         misc_sel_b = misc;
      end
      for (int g = 0; g < gap; g++) begin
         @(posedge clk); #2;
         in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = 8'h00;
      end
   endtask

   task automatic go_idle(input int n);
      for (int g = 0; g < n; g++) begin
         @(posedge clk); #2;
         in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = 8'h00;
      end
   endtask

   initial begin
      for (int k = 0; k < 256; k++) hist[k] = '0;
      repeat (5) @(posedge clk);
      #2 rst_n = 1'b1;
      mon_on = 1'b1;
      @(negedge clk);
      // R9: reset state
      check(!out_valid && out_sel == 2'b00 && !out_malformed && out_data == 8'h00,
            "R9", "reset outputs", int'({out_valid, out_malformed, out_sel}), 0);

      // R1 R2 R3 R4 R5: sweep IHL, protocol, port and misc queue
      for (int ihl = 5; ihl <= 15; ihl++) begin
         for (int pi = 0; pi < 5; pi++) begin
            for (int qi = 0; qi < 3; qi++) begin
               for (int m = 0; m < 2; m++) begin
                  logic [7:0]  pr;
                  logic [15:0] pt;
                  pr = (pi == 0) ? 8'd1 : (pi == 1) ? 8'd6 : (pi == 2) ? 8'd17 :
                       (pi == 3) ? 8'd47 : 8'd255;
                  pt = (qi == 0) ? 16'd80 : (qi == 1) ? 16'd81 : 16'h5000;
                  send(16'h0800, 4'd4, 4'(ihl), pr, pt, 14 + 4 * ihl + 12, m[0], 2, "");
               end
            end
         end
      end

      // R4: non-IPv4 EtherType and wrong version
      send(16'h86DD, 4'd6, 4'd5, 8'd6, 16'd80, 60, 1'b0, 1, "R4");
      send(16'h0806, 4'd4, 4'd5, 8'd6, 16'd80, 60, 1'b0, 1, "R4");
      send(16'h0800, 4'd6, 4'd5, 8'd6, 16'd80, 60, 1'b0, 1, "R4");
      send(16'h0801, 4'd4, 4'd5, 8'd1, 16'd80, 14, 1'b0, 1, "R4");

      // R6: IHL below 5 is malformed
      for (int ihl = 0; ihl < 5; ihl++)
         send(16'h0800, 4'd4, 4'(ihl), 8'd6, 16'd80, 60, 1'b0, 1, "R6");

      // R6: truncated TCP web frame, lengths around the port field boundary
      for (int len = 1; len <= 40; len++)
         send(16'h0800, 4'd4, 4'd5, 8'd6, 16'd80, len, 1'b0, 1, "");
      // R6: truncated ICMP frames around the protocol byte
      for (int len = 20; len <= 26; len++)
         send(16'h0800, 4'd4, 4'd5, 8'd1, 16'd0, len, 1'b0, 1, "");

      // R10: back-to-back frames with no idle cycle, down to one byte
      for (int len = 1; len <= 40; len++)
         send(16'h0800, 4'd4, 4'd5, 8'd17, 16'd53, len, len[0], 0, "R10");
      for (int k = 0; k < 8; k++)
         send(16'h0800, 4'd4, 4'd5, 8'd6, (k[0] ? 16'd80 : 16'd443), 38, 1'b0, 0, "R10");

      go_idle(DLY + 20);
      @(negedge clk);
      check(rd_p == wr_p, "R10", "frames emerged", rd_p, wr_p);
      summary();
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", rd_p, wr_p);
         summary();
      end
   end

endmodule